// File: doc/BRIEF.md
# Link-Gated Stream Packet Flusher

This block sits on a packet stream ahead of a network MAC. A level-sensitive `flush_en` input, driven high whenever the link is down, puts it into drop mode. In drop mode every upstream beat is accepted and thrown away, so the sender never stalls behind a MAC that cannot drain. When `flush_en` is low the block is a wire. The valid/ready handshake and the data pass straight through.

Drop mode is entered and left only between packets, so the downstream side always sees whole frames. A packet already under way when `flush_en` rises is forwarded to its last beat. A packet already being dropped when `flush_en` falls is dropped to its last beat.

An optional idle timeout lets the block give up on a dropped packet whose tail never arrives. The stream word carries a user sideband above the data word, and the two move together.

Top module: `pkt_flush_gate`

## Requirements
- R1: During and after reset, with no packet open, `flushing` and `done` are 0 and the block is in pass mode.
- R2: In pass mode the block is combinationally transparent: `m_tvalid` equals `s_tvalid`, `s_tready` equals `m_tready`, and `m_tdata`/`m_tlast` equal `s_tdata`/`s_tlast`.
- R3: If `flush_en` rises while a packet is open, the remaining beats of that packet are forwarded. `flushing` rises in the cycle after the beat with `s_tlast`=1 is accepted.
- R4: While `flushing` is 1, `s_tready` is 1 whatever `m_tready` is.
- R5: While `flushing` is 1, `m_tvalid` is 0 and every accepted input beat is discarded.
- R6: If `flush_en` falls while a dropped packet is open, beats keep being discarded through its `s_tlast` beat. The next packet is forwarded.
- R7: `done` is 1 for exactly one cycle, the first cycle in which `flushing` is 0 after a drop episode that ended on a packet boundary.
- R8: With `timeout_en`=0, an unfinished dropped packet holds the block in drop mode indefinitely, however long the input stays idle.
- R9: With `timeout_en`=1, after `flush_en` falls inside a dropped packet, the block returns to pass mode once `s_tvalid` has been low for 2^TIMEOUT_W-1 consecutive cycles (15 by default). It then treats the framing as closed and does not pulse `done`.
- R10: The stream word is USER_W+WORD_W bits wide, with the user sideband in the top USER_W bits. The whole word passes unchanged.
- R11: If `flush_en` is 1 while no packet is open, `flushing` rises on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_en | input | 1 | Drop-mode request (level) |
| timeout_en | input | 1 | Enables the idle timeout inside an unfinished dropped packet |
| s_tdata | input | USER_W+WORD_W | Upstream word, sideband on top |
| s_tlast | input | 1 | Upstream last beat of packet |
| s_tvalid | input | 1 | Upstream valid |
| s_tready | output | 1 | Upstream ready |
| m_tdata | output | USER_W+WORD_W | Downstream word |
| m_tlast | output | 1 | Downstream last beat |
| m_tvalid | output | 1 | Downstream valid |
| m_tready | input | 1 | Downstream ready |
| flushing | output | 1 | Drop mode active |
| done | output | 1 | One-cycle pulse when drop mode ends on a boundary |

## Verification
The hardest situations to reach are the two exits from an unfinished dropped packet. One needs drop mode, then a non-last beat, then `flush_en` falling mid-packet, then a long idle stretch. The stimulus builds that sequence directly. It holds the idle stretch with `timeout_en` low and checks that drop mode persists. It repeats the stretch with `timeout_en` high and checks both sides of the limit. After the timeout exit it raises `flush_en` with no tail beat, to show that the framing was really closed.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic {
    ST_PASS = 1'b0,
    ST_DROP = 1'b1
  } pfg_state_e;
endpackage

// File: rtl/pfg_frame_track.sv
// Tracks whether a packet is open on the input side.
module pfg_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_acc,
  input  logic beat_last,
  input  logic force_close,
  output logic open_q,
  output logic open_nx
);
  always_comb begin
    open_nx = open_q;
    if (force_close)   open_nx = 1'b0;
    else if (beat_acc) open_nx = !beat_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_nx;
  end
endmodule

// File: rtl/pfg_flush_fsm.sv
// Pass/drop mode controller with boundary-aligned transitions and idle timeout.
module pfg_flush_fsm
  import pfg_pkg::*;
#(
  parameter int TIMEOUT_W     = 4,
  parameter bit FLUSH_PARTIAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_en,
  input  logic timeout_en,
  input  logic s_valid,
  input  logic open_q,
  input  logic open_nx,
  output logic drop_mode,
  output logic done_q,
  output logic tmo_hit
);
  localparam logic [TIMEOUT_W-1:0] IDLE_LIMIT = {TIMEOUT_W{1'b1}};

  pfg_state_e st_q, st_nx;
  logic       done_nx;
  logic [TIMEOUT_W-1:0] idle_q, idle_nx;
  logic       idle_cond;
  logic       enter_ok;

  // Entry rule selected by parameter.
  generate
    if (FLUSH_PARTIAL) begin : g_partial
      assign enter_ok = flush_en;
    end else begin : g_whole
      assign enter_ok = flush_en && !open_nx;
    end
  endgenerate

  assign idle_cond = (st_q == ST_DROP) && !flush_en && open_q && !s_valid;
  assign tmo_hit   = timeout_en && idle_cond && (idle_q == IDLE_LIMIT);

  always_comb begin
    idle_nx = idle_q;
    if (!idle_cond)                idle_nx = '0;
    else if (idle_q != IDLE_LIMIT) idle_nx = idle_q + 1'b1;
  end

  always_comb begin
    st_nx   = st_q;
    done_nx = 1'b0;
    case (st_q)
      ST_PASS: if (enter_ok) st_nx = ST_DROP;
      ST_DROP: begin
        if (tmo_hit) begin
          st_nx = ST_PASS;
        end else if (!flush_en && !open_nx) begin
          st_nx   = ST_PASS;
          done_nx = 1'b1;
        end
      end
      default: st_nx = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PASS;
      done_q <= 1'b0;
      idle_q <= '0;
    end else begin
      st_q   <= st_nx;
      done_q <= done_nx;
      idle_q <= idle_nx;
    end
  end

  assign drop_mode = (st_q == ST_DROP);
endmodule

// File: rtl/pfg_steer.sv
// Handshake steering: transparent in pass mode, sink in drop mode.
module pfg_steer (
  input  logic drop_mode,
  input  logic s_tvalid,
  input  logic m_tready,
  output logic s_tready,
  output logic m_tvalid
);
  always_comb begin
    if (drop_mode) begin
      s_tready = 1'b1;
      m_tvalid = 1'b0;
    end else begin
      s_tready = m_tready;
      m_tvalid = s_tvalid;
    end
  end
endmodule

// File: rtl/pkt_flush_gate.sv
module pkt_flush_gate #(
  parameter int WORD_W        = 64,
  parameter int USER_W        = 4,
  parameter int TIMEOUT_W     = 4,
  parameter bit FLUSH_PARTIAL = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_en,
  input  logic                     timeout_en,
  input  logic [USER_W+WORD_W-1:0] s_tdata,
  input  logic                     s_tlast,
  input  logic                     s_tvalid,
  output logic                     s_tready,
  output logic [USER_W+WORD_W-1:0] m_tdata,
  output logic                     m_tlast,
  output logic                     m_tvalid,
  input  logic                     m_tready,
  output logic                     flushing,
  output logic                     done
);
  localparam int DATA_W = USER_W + WORD_W;

  logic open_q, open_nx, tmo_hit, drop_mode, beat_acc;

  assign beat_acc = s_tvalid && s_tready;

  pfg_frame_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_acc    (beat_acc),
    .beat_last   (s_tlast),
    .force_close (tmo_hit),
    .open_q      (open_q),
    .open_nx     (open_nx)
  );

  pfg_flush_fsm #(
    .TIMEOUT_W     (TIMEOUT_W),
    .FLUSH_PARTIAL (FLUSH_PARTIAL)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_en   (flush_en),
    .timeout_en (timeout_en),
    .s_valid    (s_tvalid),
    .open_q     (open_q),
    .open_nx    (open_nx),
    .drop_mode  (drop_mode),
    .done_q     (done),
    .tmo_hit    (tmo_hit)
  );

  pfg_steer u_steer (
    .drop_mode (drop_mode),
    .s_tvalid  (s_tvalid),
    .m_tready  (m_tready),
    .s_tready  (s_tready),
    .m_tvalid  (m_tvalid)
  );

  assign m_tdata  = s_tdata[DATA_W-1:0];
  assign m_tlast  = s_tlast;
  assign flushing = drop_mode;
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter bit FLUSH_PARTIAL = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic s_tvalid,
  input logic s_tready,
  input logic m_tvalid,
  input logic m_tready,
  input logic m_tlast,
  input logic flushing,
  input logic done
);
  // Output-side framing, rebuilt from the downstream handshake.
  logic out_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_open <= 1'b0;
    else if (m_tvalid && m_tready) out_open <= !m_tlast;
  end

  a_r4_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> s_tready);

  a_r5_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !m_tvalid);

  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    !flushing |-> (m_tvalid == s_tvalid) && (s_tready == m_tready));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_at_exit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flushing && $past(flushing));

  generate
    if (!FLUSH_PARTIAL) begin : g_whole
      a_r3_whole_frames: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flushing) |-> !out_open);
    end
  endgenerate
endmodule

bind pkt_flush_gate pfg_checker #(.FLUSH_PARTIAL(FLUSH_PARTIAL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_tvalid (s_tvalid),
  .s_tready (s_tready),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tlast  (m_tlast),
  .flushing (flushing),
  .done     (done)
);

// File: tb/pkt_flush_gate_tb.sv
`timescale 1ns/1ps
module pkt_flush_gate_tb;
  localparam int DW = 68;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_en = 1'b0, timeout_en = 1'b0;
  logic [DW-1:0] s_tdata = '0;
  logic s_tlast = 1'b0, s_tvalid = 1'b0, m_tready = 1'b0;
  logic s_tready, m_tlast, m_tvalid, flushing, done;
  logic [DW-1:0] m_tdata;

  int n_chk = 0, n_bad = 0, done_cnt = 0;

  always #2 clk = ~clk;

  pkt_flush_gate u_dut (
    .clk(clk), .rst_n(rst_n), .flush_en(flush_en), .timeout_en(timeout_en),
    .s_tdata(s_tdata), .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .flushing(flushing), .done(done)
  );

  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic l, input logic [DW-1:0] d);
    s_tvalid = v; s_tlast = l; s_tdata = d;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "flushing in reset", DW'(flushing), 0);
    chk("R1", "done in reset", DW'(done), 0);
    rst_n = 1'b1; m_tready = 1'b1;
    step();
    chk("R1", "flushing after reset", DW'(flushing), 0);
    chk("R1", "s_tready after reset", DW'(s_tready), 1);
    chk("R1", "m_tvalid after reset", DW'(m_tvalid), 0);
  endtask

  task automatic t_pass();
    logic [DW-1:0] d1 = {4'hA, 64'h0123_4567_89AB_CDEF};
    logic [DW-1:0] d2 = {4'h5, 64'hFEDC_BA98_7654_3210};
    m_tready = 1'b1; put(1, 0, d1); #1;
    chk("R2", "m_tvalid", DW'(m_tvalid), 1);
    chk("R10", "m_tdata with sideband", m_tdata, d1);
    chk("R2", "m_tlast", DW'(m_tlast), 0);
    step();
    m_tready = 1'b0; put(1, 1, d2); #1;
    chk("R2", "s_tready follows stall", DW'(s_tready), 0);
    chk("R10", "held word", m_tdata, d2);
    chk("R2", "m_tlast", DW'(m_tlast), 1);
    step();
    m_tready = 1'b1; #1;
    chk("R2", "s_tready follows ready", DW'(s_tready), 1);
    step();
    put(0, 0, '0); #1;
    chk("R2", "m_tvalid idle", DW'(m_tvalid), 0);
    chk("R2", "still passing", DW'(flushing), 0);
  endtask

  task automatic t_idle_flush();
    flush_en = 1'b1; #1;
    chk("R11", "flushing before edge", DW'(flushing), 0);
    step();
    chk("R11", "flushing after edge", DW'(flushing), 1);
    m_tready = 1'b0; put(1, 0, 68'h11); #1;
    chk("R4", "s_tready while stalled", DW'(s_tready), 1);
    chk("R5", "m_tvalid low", DW'(m_tvalid), 0);
    step();
    put(1, 1, 68'h12); #1;
    chk("R5", "m_tvalid low tail", DW'(m_tvalid), 0);
    step();
    put(0, 0, '0); flush_en = 1'b0;
    step();
    chk("R7", "flushing after boundary exit", DW'(flushing), 0);
    chk("R7", "done pulse", DW'(done), 1);
    step();
    chk("R7", "done one cycle", DW'(done), 0);
    m_tready = 1'b1;
  endtask

  task automatic t_mid_enable();
    m_tready = 1'b1; put(1, 0, 68'h21);
    step();
    flush_en = 1'b1; put(1, 0, 68'h22); #1;
    chk("R3", "middle beat forwarded", DW'(m_tvalid), 1);
    chk("R3", "middle data", m_tdata, 68'h22);
    step();
    chk("R3", "no flush mid-packet", DW'(flushing), 0);
    put(1, 1, 68'h23); #1;
    chk("R3", "tail forwarded", DW'(m_tvalid), 1);
    step();
    chk("R3", "flush after tail", DW'(flushing), 1);
    put(1, 0, 68'h24); #1;
    chk("R5", "next packet dropped", DW'(m_tvalid), 0);
    step();
  endtask

  task automatic t_mid_exit();
    int d0;
    d0 = done_cnt;
    flush_en = 1'b0; put(1, 0, 68'h31); #1;
    chk("R6", "still dropping", DW'(m_tvalid), 0);
    chk("R4", "still accepting", DW'(s_tready), 1);
    step();
    chk("R6", "flushing held", DW'(flushing), 1);
    chk("R6", "no done yet", DW'(done_cnt - d0), 0);
    put(1, 1, 68'h32); #1;
    chk("R6", "tail dropped", DW'(m_tvalid), 0);
    step();
    chk("R6", "pass resumed", DW'(flushing), 0);
    chk("R7", "done on exit", DW'(done), 1);
    put(1, 1, 68'h33); #1;
    chk("R6", "next packet forwarded", DW'(m_tvalid), 1);
    chk("R6", "next data", m_tdata, 68'h33);
    step();
    chk("R7", "done cleared", DW'(done), 0);
    put(0, 0, '0);
  endtask

  task automatic t_tmo_off();
    int d0;
    flush_en = 1'b1; step();
    put(1, 0, 68'h41); step();
    put(0, 0, '0); flush_en = 1'b0; timeout_en = 1'b0;
    d0 = done_cnt;
    repeat (20) step();
    chk("R8", "held without timeout", DW'(flushing), 1);
    chk("R8", "no done", DW'(done_cnt - d0), 0);
    put(1, 1, 68'h42); step();
    put(0, 0, '0);
    chk("R8", "tail closes episode", DW'(flushing), 0);
    step();
  endtask

  task automatic t_tmo_on();
    int d0;
    flush_en = 1'b1; step();
    put(1, 0, 68'h51); step();
    put(0, 0, '0); flush_en = 1'b0; timeout_en = 1'b1;
    d0 = done_cnt;
    repeat (10) step();
    chk("R9", "not before limit", DW'(flushing), 1);
    repeat (10) step();
    chk("R9", "exit after limit", DW'(flushing), 0);
    chk("R9", "no done on timeout", DW'(done_cnt - d0), 0);
    flush_en = 1'b1; step();
    chk("R9", "framing closed", DW'(flushing), 1);
    flush_en = 1'b0; timeout_en = 1'b0; step();
    step();
  endtask

  initial begin
    t_reset();
    t_pass();
    t_idle_flush();
    t_mid_enable();
    t_mid_exit();
    t_tmo_off();
    t_tmo_on();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule